// File: doc/BRIEF.md
# Display Control Register Unit

This block sits on the control side of a graphics engine. Software writes 32-bit control words to it, one word per write strobe. The top byte of each word selects an operation, and the low 24 bits carry that operation's argument. The block decodes each word into a set of display settings: blanking, DMA direction, display origin, horizontal and vertical display windows, and video mode. It also keeps a 32-bit status word, which the host reads.

The video mode is stored only as bits inside the status word. The horizontal and vertical resolutions are looked up from those status bits every cycle. A small sequential divider computes the effective horizontal display width from the horizontal window and the current horizontal resolution, and it raises a one-cycle done strobe when the new width is available. Each opcode inside the register-array range also has a shadow register that holds the last argument written with that opcode. A select input reads these shadow registers back.

Top module: `disp_ctrl_regs`

## Requirements
- R1: While rst_ni is low the status word is 0x14802000, with blank_o=1, dma_dir_o=0, all origin and window fields 0, hres_o=256, vres_o=240 and width_o=256. Every shadow register reads 0.
- R2: A write with opcode 0x00 loads the status word with 0x14802000, which has blank bit 23 set. The origin and window fields keep their values.
- R3: Opcode 0x03 copies data bit 0 into status bit 23, and blank_o follows that bit.
- R4: Opcode 0x04 copies data bits 1:0 into status bits 30:29, and dma_dir_o follows those bits.
- R5: Opcode 0x05 sets disp_x_o from data bits 9:0 and disp_y_o from data bits 19:10.
- R6: Opcode 0x06 sets hx1_o from data bits 11:0 and hx2_o from data bits 23:12. Opcode 0x07 sets vy1_o from data bits 9:0 and vy2_o from data bits 19:10.
- R7: Opcode 0x08 replaces status bits 22:16 as follows. Data bits 5:0 go to status bits 22:17, and data bit 6 goes to status bit 16. All other status bits are kept.
- R8: hres_o is taken from status bits 18:16 through the table 0..7 → 256,368,320,384,512,512,640,640. vres_o is taken from status bits 20:19 through the table 0..3 → 240,480,256,480.
- R9: Let s = hx2_o − hx1_o, a signed value. width_o becomes floor(s·hres/2560). If s ≤ 0 or s ≥ 2560, width_o becomes hres instead.
- R10: After every write whose opcode is below NUM_SHADOW, width_done_o is high for exactly one cycle. This happens 22 clock edges after the write edge, and width_o takes its new value in that same cycle. A later accepted write restarts the computation.
- R11: status_o bit 31 equals line_flag_i in the same cycle. Bits 30:0 of status_o are the stored status word.
- R12: A write with opcode below NUM_SHADOW (default 16) stores data bits 23:0 in the shadow register for that opcode. shadow_o shows the shadow register chosen by shadow_sel_i. A write with an opcode of NUM_SHADOW or above changes nothing: no status bit, no field, no shadow register, and no done strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_data_i | input | 32 | Control word; bits 31:24 are the opcode |
| line_flag_i | input | 1 | Line flag reported in status bit 31 |
| shadow_sel_i | input | $clog2(NUM_SHADOW) | Shadow register read select |
| shadow_o | output | 24 | Selected shadow register contents |
| status_o | output | 32 | Status word with the line flag in bit 31 |
| blank_o | output | 1 | Display blanked |
| dma_dir_o | output | 2 | DMA direction field |
| disp_x_o | output | 10 | Display origin X |
| disp_y_o | output | 10 | Display origin Y |
| hx1_o | output | 12 | Horizontal window start |
| hx2_o | output | 12 | Horizontal window end |
| vy1_o | output | 10 | Vertical window start |
| vy2_o | output | 10 | Vertical window end |
| hres_o | output | 10 | Horizontal resolution |
| vres_o | output | 9 | Vertical resolution |
| width_o | output | 10 | Effective display width |
| width_done_o | output | 1 | Width result valid strobe |

## Verification
A wrong bit in the stored status word shows on status_o in the first cycle after the write that sets it. A wrong mode bit also shows on hres_o or vres_o in that same cycle, because both are decoded from the word without any register in between. A divider fault appears only when width_done_o fires, 22 cycles after the write. So the bench checks both the width value and the strobe timing on every window and mode combination it drives. A shadow register or an ignored-opcode leak stays hidden until that entry is selected or the status is compared, so the bench reads back every shadow entry after each sweep.

// File: rtl/disp_ctrl_pkg.sv
package disp_ctrl_pkg;
  localparam logic [7:0] OP_RESET = 8'h00;
  localparam logic [7:0] OP_BLANK = 8'h03;
  localparam logic [7:0] OP_DMA   = 8'h04;
  localparam logic [7:0] OP_START = 8'h05;
  localparam logic [7:0] OP_HWIN  = 8'h06;
  localparam logic [7:0] OP_VWIN  = 8'h07;
  localparam logic [7:0] OP_MODE  = 8'h08;

  localparam logic [31:0] STATUS_INIT = 32'h1480_2000;
  localparam int BLANK_BIT = 23;
  localparam int DMA_LSB   = 29;
  localparam int MODE_LSB  = 16;

  localparam int HRES_W   = 10;
  localparam int VRES_W   = 9;
  localparam int SPAN     = 2560;
  localparam int DIV_W    = 21;  // covers 640*2560
  localparam int REM_W    = 13;

  typedef struct packed {
    logic [9:0]  x;
    logic [9:0]  y;
    logic [11:0] x1;
    logic [11:0] x2;
    logic [9:0]  y1;
    logic [9:0]  y2;
  } geom_t;

  function automatic logic [HRES_W-1:0] hres_of(input logic [2:0] sel);
    case (sel)
      3'd0: hres_of = 10'd256;
      3'd1: hres_of = 10'd368;
      3'd2: hres_of = 10'd320;
      3'd3: hres_of = 10'd384;
      3'd4, 3'd5: hres_of = 10'd512;
      default: hres_of = 10'd640;
    endcase
  endfunction

  function automatic logic [VRES_W-1:0] vres_of(input logic [1:0] sel);
    case (sel)
      2'd0: vres_of = 9'd240;
      2'd2: vres_of = 9'd256;
      default: vres_of = 9'd480;
    endcase
  endfunction
endpackage

// File: rtl/disp_ctrl_shadow.sv
module disp_ctrl_shadow #(
  parameter int NUM_SHADOW = 16,
  localparam int SEL_W = $clog2(NUM_SHADOW)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] wsel_i,
  input  logic [23:0]      wdata_i,
  input  logic [SEL_W-1:0] rsel_i,
  output logic [23:0]      rdata_o
);
  logic [23:0] regs_q [NUM_SHADOW];

  for (genvar i = 0; i < NUM_SHADOW; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[i] <= '0;
      else if (we_i && (wsel_i == SEL_W'(i))) regs_q[i] <= wdata_i;
    end
  end

  assign rdata_o = regs_q[rsel_i];
endmodule

// File: rtl/disp_ctrl_decode.sv
module disp_ctrl_decode
  import disp_ctrl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] data_i,
  output logic [31:0] status_o,
  output geom_t       geom_o
);
  logic [31:0] status_q;
  geom_t       geom_q;
  logic [7:0]  op;

  assign op = data_i[31:24];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= STATUS_INIT;
      geom_q   <= '0;
    end else if (we_i) begin
      case (op)
        OP_RESET: status_q <= STATUS_INIT | (32'd1 << BLANK_BIT);
        OP_BLANK: status_q[BLANK_BIT] <= data_i[0];
        OP_DMA:   status_q[DMA_LSB+:2] <= data_i[1:0];
        OP_START: begin
          geom_q.x <= data_i[9:0];
          geom_q.y <= data_i[19:10];
        end
        OP_HWIN: begin
          geom_q.x1 <= data_i[11:0];
          geom_q.x2 <= data_i[23:12];
        end
        OP_VWIN: begin
          geom_q.y1 <= data_i[9:0];
          geom_q.y2 <= data_i[19:10];
        end
        // mode bits land out of order: bit 6 goes to the lowest slot
        OP_MODE:  status_q[MODE_LSB+:7] <= {data_i[5:0], data_i[6]};
        default: ;
      endcase
    end
  end

  assign status_o = status_q;
  assign geom_o   = geom_q;
endmodule

// File: rtl/disp_ctrl_width.sv
module disp_ctrl_width
  import disp_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [11:0]       x1_i,
  input  logic [11:0]       x2_i,
  input  logic [HRES_W-1:0] hres_i,
  output logic [HRES_W-1:0] width_o,
  output logic              done_o
);
  localparam int CNT_W = $clog2(DIV_W + 1);

  logic signed [12:0] span;
  logic               fallback;
  logic [DIV_W-1:0]   dividend;
  logic [REM_W-1:0]   rem_q, rem_sh, rem_nx;
  logic [DIV_W-1:0]   quo_q, quo_nx;
  logic [CNT_W-1:0]   cnt_q;
  logic               busy_q, ge;
  logic [HRES_W-1:0]  width_q;
  logic               done_q;

  assign span     = $signed({1'b0, x2_i}) - $signed({1'b0, x1_i});
  assign fallback = span[12] || (span == 13'sd0) || (span >= 13'sd2560);
  // fallback feeds hres*SPAN so the quotient is exactly hres
  assign dividend = fallback ? DIV_W'(hres_i) * DIV_W'(SPAN)
                             : DIV_W'(span[11:0]) * DIV_W'(hres_i);

  assign rem_sh = {rem_q[REM_W-2:0], quo_q[DIV_W-1]};
  assign ge     = rem_sh >= REM_W'(SPAN);
  assign rem_nx = ge ? rem_sh - REM_W'(SPAN) : rem_sh;
  assign quo_nx = {quo_q[DIV_W-2:0], ge};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      rem_q   <= '0;
      quo_q   <= '0;
      width_q <= hres_of(3'd0);
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(DIV_W);
        rem_q  <= '0;
        quo_q  <= dividend;
      end else if (busy_q) begin
        rem_q <= rem_nx;
        quo_q <= quo_nx;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q  <= 1'b0;
          width_q <= quo_nx[HRES_W-1:0];
          done_q  <= 1'b1;
        end
      end
    end
  end

  assign width_o = width_q;
  assign done_o  = done_q;
endmodule

// File: rtl/disp_ctrl_regs.sv
module disp_ctrl_regs
  import disp_ctrl_pkg::*;
#(
  parameter int NUM_SHADOW = 16,
  localparam int SEL_W = $clog2(NUM_SHADOW)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic [31:0]       ctl_data_i,
  input  logic              line_flag_i,
  input  logic [SEL_W-1:0]  shadow_sel_i,
  output logic [23:0]       shadow_o,
  output logic [31:0]       status_o,
  output logic              blank_o,
  output logic [1:0]        dma_dir_o,
  output logic [9:0]        disp_x_o,
  output logic [9:0]        disp_y_o,
  output logic [11:0]       hx1_o,
  output logic [11:0]       hx2_o,
  output logic [9:0]        vy1_o,
  output logic [9:0]        vy2_o,
  output logic [HRES_W-1:0] hres_o,
  output logic [VRES_W-1:0] vres_o,
  output logic [HRES_W-1:0] width_o,
  output logic              width_done_o
);
  logic        accept;
  logic        start_q;
  logic [31:0] status_w;
  geom_t       geom_w;

  assign accept = ctl_we_i && (32'(ctl_data_i[31:24]) < NUM_SHADOW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_q <= 1'b0;
    else         start_q <= accept;
  end

  disp_ctrl_shadow #(.NUM_SHADOW(NUM_SHADOW)) u_shadow (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (accept),
    .wsel_i  (ctl_data_i[24+:SEL_W]),
    .wdata_i (ctl_data_i[23:0]),
    .rsel_i  (shadow_sel_i),
    .rdata_o (shadow_o)
  );

  disp_ctrl_decode u_decode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (accept),
    .data_i   (ctl_data_i),
    .status_o (status_w),
    .geom_o   (geom_w)
  );

  assign hres_o = hres_of(status_w[MODE_LSB+:3]);
  assign vres_o = vres_of(status_w[MODE_LSB+3+:2]);

  disp_ctrl_width u_width (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_q),
    .x1_i    (geom_w.x1),
    .x2_i    (geom_w.x2),
    .hres_i  (hres_o),
    .width_o (width_o),
    .done_o  (width_done_o)
  );

  assign status_o  = {status_w[31] | line_flag_i, status_w[30:0]};
  assign blank_o   = status_w[BLANK_BIT];
  assign dma_dir_o = status_w[DMA_LSB+:2];
  assign disp_x_o  = geom_w.x;
  assign disp_y_o  = geom_w.y;
  assign hx1_o     = geom_w.x1;
  assign hx2_o     = geom_w.x2;
  assign vy1_o     = geom_w.y1;
  assign vy2_o     = geom_w.y2;
endmodule

// File: rtl/disp_ctrl_regs_chk.sv
module disp_ctrl_regs_chk #(
  parameter int NUM_SHADOW = 16
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ctl_we_i,
  input logic [31:0] ctl_data_i,
  input logic        line_flag_i,
  input logic [31:0] status_o,
  input logic        blank_o,
  input logic [1:0]  dma_dir_o,
  input logic [9:0]  hres_o,
  input logic [9:0]  width_o,
  input logic        width_done_o
);
  logic ignored;
  assign ignored = ctl_we_i && (32'(ctl_data_i[31:24]) >= NUM_SHADOW);

  p_blank_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i && ctl_data_i[31:24] == 8'h03 |=> blank_o == $past(ctl_data_i[0]));

  p_dma_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i && ctl_data_i[31:24] == 8'h04 |=> dma_dir_o == $past(ctl_data_i[1:0]));

  p_mode_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i && ctl_data_i[31:24] == 8'h08 |=>
      status_o[22:16] == {$past(ctl_data_i[5:0]), $past(ctl_data_i[6])});

  p_reset_cmd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i && ctl_data_i[31:24] == 8'h00 |=> status_o[30:0] == 31'h1480_2000);

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    width_done_o |=> !width_done_o);

  p_width_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    width_done_o |-> width_o <= hres_o);

  p_ignore_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ignored |=> $stable(status_o[30:0]));

  always_comb begin
    if (rst_ni) p_flag_r11: assert (status_o[31] == line_flag_i);
  end
endmodule

bind disp_ctrl_regs disp_ctrl_regs_chk #(.NUM_SHADOW(NUM_SHADOW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ctl_we_i     (ctl_we_i),
  .ctl_data_i   (ctl_data_i),
  .line_flag_i  (line_flag_i),
  .status_o     (status_o),
  .blank_o      (blank_o),
  .dma_dir_o    (dma_dir_o),
  .hres_o       (hres_o),
  .width_o      (width_o),
  .width_done_o (width_done_o)
);

// File: tb/disp_ctrl_regs_test.sv
module disp_ctrl_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int NSH = 16;
  localparam int LAT = 22;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] data = '0;
  logic        lflag = 1'b0;
  logic [3:0]  ssel = '0;
  logic [23:0] shadow;
  logic [31:0] status;
  logic        blank, done;
  logic [1:0]  dma;
  logic [9:0]  dx, dy, y1, y2, hres, width;
  logic [11:0] x1, x2;
  logic [8:0]  vres;

  int checks = 0;
  int fails = 0;
  logic [23:0] exp_sh [NSH];

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_ctrl_regs #(.NUM_SHADOW(NSH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ctl_we_i(we), .ctl_data_i(data),
    .line_flag_i(lflag), .shadow_sel_i(ssel), .shadow_o(shadow),
    .status_o(status), .blank_o(blank), .dma_dir_o(dma),
    .disp_x_o(dx), .disp_y_o(dy), .hx1_o(x1), .hx2_o(x2),
    .vy1_o(y1), .vy2_o(y2), .hres_o(hres), .vres_o(vres),
    .width_o(width), .width_done_o(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int ref_hres(input int s);
    case (s)
      0: return 256; 1: return 368; 2: return 320; 3: return 384;
      4, 5: return 512; default: return 640;
    endcase
  endfunction

  function automatic int ref_vres(input int s);
    case (s)
      0: return 240; 2: return 256; default: return 480;
    endcase
  endfunction

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; data = d;
    @(negedge clk);
    we = 1'b0;
    if (d[31:24] < NSH) exp_sh[d[27:24]] = d[23:0];
  endtask

  // returns negedges from write until done strobe seen
  task automatic wait_done(output int lat);
    lat = 0;
    while (!done && lat < 60) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic check_shadows(input string req);
    for (int i = 0; i < NSH; i++) begin
      ssel = 4'(i);
      #1;
      chk(req, 32'(shadow), 32'(exp_sh[i]));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int lat;
    int hs, sw, ew;
    int pairs [7][2];
    logic [31:0] base;
    for (int i = 0; i < NSH; i++) exp_sh[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 status", status, 32'h1480_2000);
    chk("R1 blank", 32'(blank), 1);
    chk("R1 dma", 32'(dma), 0);
    chk("R1 geom", {dx, dy, x1[3:0], 8'h0} | 32'(x2) | 32'(y1) | 32'(y2), 0);
    chk("R1 hres", 32'(hres), 256);
    chk("R1 vres", 32'(vres), 240);
    chk("R1 width", 32'(width), 256);
    check_shadows("R1 shadow");
    rst_n = 1'b1;
    @(negedge clk);

    // R11 line flag passthrough
    lflag = 1'b1; #1;
    chk("R11 flag high", 32'(status[31]), 1);
    chk("R11 low bits", {1'b0, status[30:0]}, 32'h1480_2000);
    lflag = 1'b0; #1;
    chk("R11 flag low", 32'(status[31]), 0);

    // R3 blanking
    wr(32'h0300_0000); wait_done(lat);
    chk("R3 blank off", 32'(blank), 0);
    chk("R3 status bit", 32'(status[23]), 0);
    wr(32'h03FF_FFFF); wait_done(lat);
    chk("R3 blank on", 32'(blank), 1);
    wr(32'h0300_0000); wait_done(lat);

    // R4 dma sweep
    for (int d = 0; d < 4; d++) begin
      wr(32'h0400_0000 | 32'(d)); wait_done(lat);
      chk("R4 dma", 32'(dma), 32'(d));
      chk("R4 status", 32'(status[30:29]), 32'(d));
    end

    // R5 origin
    wr({8'h05, 4'hF, 10'h2A5, 10'h1C3}); wait_done(lat);
    chk("R5 x", 32'(dx), 32'h1C3);
    chk("R5 y", 32'(dy), 32'h2A5);

    // R6 vertical window
    wr({8'h07, 4'h0, 10'h3FF, 10'h011}); wait_done(lat);
    chk("R6 y1", 32'(y1), 32'h011);
    chk("R6 y2", 32'(y2), 32'h3FF);

    // R7 R8 full mode sweep
    base = status & ~32'h007F_0000;
    for (int m = 0; m < 128; m++) begin
      logic [6:0] mv;
      mv = 7'(m);
      wr(32'h0800_0000 | 32'(m)); wait_done(lat);
      chk("R7 mode bits", 32'(status[22:16]), 32'({mv[5:0], mv[6]}));
      chk("R7 others kept", status & ~32'h007F_0000, base);
      chk("R8 hres", 32'(hres), 32'(ref_hres(int'({mv[1:0], mv[6]}))));
      chk("R8 vres", 32'(vres), 32'(ref_vres(int'(mv[3:2]))));
    end

    // R9 R10 width across modes and windows
    pairs = '{'{0, 0}, '{100, 2660}, '{500, 3059}, '{2000, 1000},
              '{0, 1280}, '{1, 2}, '{4095, 0}};
    for (int h = 0; h < 8; h++) begin
      // mode bits: data bit 6 -> hres bit0, data bits 1:0 -> hres bits 2:1
      wr(32'h0800_0000 | 32'(((h & 1) << 6) | (h >> 1))); wait_done(lat);
      hs = ref_hres(h);
      chk("R8 hres sel", 32'(hres), 32'(hs));
      for (int p = 0; p < 7; p++) begin
        wr({8'h06, 12'(pairs[p][1]), 12'(pairs[p][0])});
        wait_done(lat);
        chk("R10 latency", 32'(lat), LAT);
        chk("R6 x1", 32'(x1), 32'(pairs[p][0]));
        chk("R6 x2", 32'(x2), 32'(pairs[p][1]));
        sw = pairs[p][1] - pairs[p][0];
        ew = (sw <= 0 || sw >= 2560) ? hs : (sw * hs) / 2560;
        chk("R9 width", 32'(width), 32'(ew));
        @(negedge clk);
        chk("R10 one cycle", 32'(done), 0);
      end
    end

    // R10 restart: second write before done re-times the strobe
    wr({8'h06, 12'd2560, 12'd0});
    repeat (5) @(negedge clk);
    wr({8'h06, 12'd1280, 12'd0}); wait_done(lat);
    chk("R10 restart latency", 32'(lat), LAT);
    chk("R9 restart width", 32'(width), 320);

    // R2 reset command keeps geometry
    wr(32'h0400_0003); wait_done(lat);
    wr(32'h00AB_CDEF); wait_done(lat);
    chk("R2 status", status, 32'h1480_2000);
    chk("R2 blank", 32'(blank), 1);
    chk("R2 x kept", 32'(dx), 32'h1C3);
    chk("R2 hres", 32'(hres), 256);

    // R12 shadows and ignored opcodes
    for (int o = 9; o < NSH; o++) begin
      wr({8'(o), 24'(o * 24'h01_0203)}); wait_done(lat);
    end
    check_shadows("R12 shadow");
    base = status;
    for (int o = NSH; o < 256; o += 37) begin
      wr({8'(o), 24'hFFFFFF});
      lat = 0;
      repeat (LAT + 2) begin
        @(negedge clk);
        if (done) lat++;
      end
      chk("R12 no strobe", 32'(lat), 0);
      chk("R12 status kept", status, base);
      chk("R12 x1 kept", 32'(x1), 0);
    end
    wr(32'hFF00_0000);
    repeat (2) @(negedge clk);
    check_shadows("R12 shadow kept");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule